// File: doc/BRIEF.md
# Passive FPGA configuration sequencer

This block loads a configuration bitstream into a target FPGA through a passive configuration port. On a start request it pulls the active-low configuration request low for a timed pulse and then releases it. It waits a settle time, and then clocks the bitstream bytes out on a configuration clock and data bus. Before each byte it checks that the target's status line is still high. After the last byte it gives one trailing rising clock edge, waits the settle time again and samples the target's done line.

Three transfer modes are chosen at start. In 1-bit serial mode each byte goes out least significant bit first, with one clock pulse per bit. In 8-bit parallel mode each byte gets one pulse. Secure parallel mode adds three extra pulses after each byte, for compressed or encrypted streams. Bytes come from a valid/ready stream, and the total length is given with the start request. The stream may stall at any point. The block reports busy, a one-cycle success or failure pulse and a held abort request, and it counts the bytes that have been completely sent.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start request with a nonzero length, accepted while idle, drives cfgReqN low from the next cycle for PULSE cycles (PULSE = CLK_FREQ_HZ/1e6 x PULSE_US, rounded up), then high. busy is high from that same cycle until the cycle in which the result is reported.
- R2: cfgClk stays low while cfgReqN is low and for SETTLE cycles after cfgReqN returns high (SETTLE = CLK_FREQ_HZ/1e6 x SETTLE_US). The first byte can be accepted no earlier than the cycle after that.
- R3: A clock pulse on cfgClk is HALF_CYC cycles low and then HALF_CYC cycles high, counted from the byte handshake or from the previous falling edge. cfgData changes only in cycles where cfgClk is low, and it is stable across each rising edge. cfgData reads zero from the start until the first byte is loaded. While the stream is stalled, cfgClk stays low and cfgData holds its value.
- R4: In serial mode (mode = 2'b00) each byte gives 8 pulses. For pulse k, cfgData[0] carries bit k of the byte, starting with bit 0, and cfgData[7:1] are zero.
- R5: In parallel mode (mode = 2'b01) the whole byte appears on cfgData and gets one pulse.
- R6: In secure parallel mode (mode[1] = 1) the byte appears on cfgData for 1+SECURE_EXTRA = 4 pulses, and cfgData stays unchanged across them.
- R7: If tgtStatus is low when the next byte is due, the block accepts no further byte. In the following cycle it pulses xferFail, sets abortReq and returns to idle. byteCount then equals the number of bytes whose pulses all completed.
- R8: After the last byte's final falling edge, cfgClk rises in the next cycle and stays high for SETTLE cycles. In the cycle after that, cfgClk falls and busy drops. xferOk pulses if tgtDone was high in the sampling cycle. Otherwise xferFail pulses and abortReq is set.
- R9: A start with totalLen = 0 while idle gives an xferFail pulse in the next cycle. busy stays low, and cfgReqN, cfgClk and cfgData do not change.
- R10: inReady is high only while the block waits for a byte, bytes remain and tgtStatus is high. Each cycle with inValid and inReady high consumes exactly one byte.
- R11: Any start accepted while idle clears abortReq in the next cycle. A start while busy has no effect on the transfer in progress.
- R12: During and after reset, cfgReqN = 1, cfgClk = 0, cfgData = 0, busy = 0, xferOk = 0, xferFail = 0, abortReq = 0 and byteCount = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| mode | input | 2 | 00 serial, 01 parallel, 1x secure parallel |
| totalLen | input | LEN_W | Number of bytes in the bitstream |
| inData | input | DATA_W | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Block takes the byte this cycle |
| tgtStatus | input | 1 | Target status line, high while healthy |
| tgtDone | input | 1 | Target configuration done line |
| cfgReqN | output | 1 | Active-low configuration request to target |
| cfgClk | output | 1 | Configuration clock to target |
| cfgData | output | DATA_W | Configuration data to target |
| busy | output | 1 | Transfer in progress |
| xferOk | output | 1 | One-cycle success pulse |
| xferFail | output | 1 | One-cycle failure pulse |
| abortReq | output | 1 | Held high after a failure on the target, until the next start |
| byteCount | output | LEN_W | Bytes fully sent in this transfer |

## Verification
Every output is due a fixed number of cycles after the edge that samples its cause. cfgReqN falls one edge after start, and it rises PULSE edges later. The first byte is taken at the first edge after a further SETTLE edges. Each clock edge then comes HALF_CYC edges after the one before, the trailing edge comes one edge after the last fall, and the result comes SETTLE edges after that. The reference model in the bench advances by those edge counts and samples start, the stream, tgtStatus and tgtDone at the same edges as the design. Its expectations are compared with every output two nanoseconds before each rising edge. Inputs change only just after falling edges, so no comparison can land in a cycle where a result is still in transit.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  // Control to datapath strobes, one cycle each
  typedef struct packed {
    logic startXfer;
    logic cfgLow;
    logic cfgHigh;
    logic clkRise;
    logic clkFall;
    logic loadByte;
    logic shiftBit;
    logic countByte;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FETCH = 3'd3,
    ST_LOW   = 3'd4,
    ST_HIGH  = 3'd5,
    ST_TAIL  = 3'd6
  } seqState_e;

  // Microseconds to system cycles, rounded up, never below one
  function automatic int unsigned usToCycles(input longint unsigned hz,
                                             input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/fcl_ctrl.sv
module fcl_ctrl
  import fcl_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SECURE_EXTRA = 3,
  parameter int unsigned PULSE_CYC    = 10,
  parameter int unsigned SETTLE_CYC   = 200,
  parameter int unsigned HALF_CYC     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       lenZero,
  input  logic       allSent,
  input  logic       tgtStatus,
  input  logic       tgtDone,
  input  logic       inValid,
  output logic       inReady,
  output logic       busy,
  output logic       xferOk,
  output logic       xferFail,
  output logic       abortReq,
  output logic       serialMode,
  output dpStrobe_t  stb
);

  localparam int unsigned HALF_EFF  = (HALF_CYC < 1) ? 1 : HALF_CYC;
  localparam int unsigned MAX_A     = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int unsigned MAX_C     = (MAX_A > HALF_EFF) ? MAX_A : HALF_EFF;
  localparam int unsigned CNT_W     = $clog2(MAX_C + 1);
  localparam int unsigned SEC_BEATS = 1 + SECURE_EXTRA;
  localparam int unsigned BEAT_MAX  = (DATA_W > SEC_BEATS) ? DATA_W : SEC_BEATS;
  localparam int unsigned BEAT_W    = $clog2(BEAT_MAX + 1);

  localparam logic [CNT_W-1:0]  PULSE_LOAD  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0]  SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0]  HALF_LOAD   = CNT_W'(HALF_EFF - 1);
  localparam logic [BEAT_W-1:0] BEATS_SER   = BEAT_W'(DATA_W);
  localparam logic [BEAT_W-1:0] BEATS_SEC   = BEAT_W'(SEC_BEATS);
  localparam logic [BEAT_W-1:0] BEATS_PAR   = BEAT_W'(1);

  seqState_e         state, stateNx;
  logic [CNT_W-1:0]  cnt, cntNx;
  logic [BEAT_W-1:0] beats, beatsNx, beatLoad;
  logic              secureMode, secureNx, serialNx;
  logic              okNx, failNx, abortNx;
  logic              cntZero;

  assign cntZero = (cnt == '0);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    if (serialMode)      beatLoad = BEATS_SER;
    else if (secureMode) beatLoad = BEATS_SEC;
    else                 beatLoad = BEATS_PAR;
  end

  always_comb begin
    stateNx  = state;
    cntNx    = cnt;
    beatsNx  = beats;
    serialNx = serialMode;
    secureNx = secureMode;
    okNx     = 1'b0;
    failNx   = 1'b0;
    abortNx  = abortReq;
    stb      = '0;
    inReady  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          abortNx = 1'b0;
          if (lenZero) begin
            failNx = 1'b1;
          end else begin
            stb.startXfer = 1'b1;
            stb.cfgLow    = 1'b1;
            serialNx      = (mode == 2'b00);
            secureNx      = mode[1];
            cntNx         = PULSE_LOAD;
            stateNx       = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        if (cntZero) begin
          stb.cfgHigh = 1'b1;
          cntNx       = SETTLE_LOAD;
          stateNx     = ST_WAIT;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_WAIT: begin
        if (cntZero) stateNx = ST_FETCH;
        else         cntNx   = cnt - 1'b1;
      end
      ST_FETCH: begin
        if (allSent) begin
          stb.clkRise = 1'b1;
          cntNx       = SETTLE_LOAD;
          stateNx     = ST_TAIL;
        end else if (!tgtStatus) begin
          failNx  = 1'b1;
          abortNx = 1'b1;
          stateNx = ST_IDLE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            stb.loadByte = 1'b1;
            beatsNx      = beatLoad;
            cntNx        = HALF_LOAD;
            stateNx      = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (cntZero) begin
          stb.clkRise = 1'b1;
          cntNx       = HALF_LOAD;
          stateNx     = ST_HIGH;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_HIGH: begin
        if (cntZero) begin
          stb.clkFall = 1'b1;
          if (beats == BEAT_W'(1)) begin
            stb.countByte = 1'b1;
            stateNx       = ST_FETCH;
          end else begin
            beatsNx      = beats - 1'b1;
            stb.shiftBit = serialMode;
            cntNx        = HALF_LOAD;
            stateNx      = ST_LOW;
          end
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_TAIL: begin
        if (cntZero) begin
          stb.clkFall = 1'b1;
          stateNx     = ST_IDLE;
          if (tgtDone) begin
            okNx = 1'b1;
          end else begin
            failNx  = 1'b1;
            abortNx = 1'b1;
          end
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      beats      <= '0;
      serialMode <= 1'b0;
      secureMode <= 1'b0;
      xferOk     <= 1'b0;
      xferFail   <= 1'b0;
      abortReq   <= 1'b0;
    end else begin
      state      <= stateNx;
      cnt        <= cntNx;
      beats      <= beatsNx;
      serialMode <= serialNx;
      secureMode <= secureNx;
      xferOk     <= okNx;
      xferFail   <= failNx;
      abortReq   <= abortNx;
    end
  end

endmodule

// File: rtl/fcl_datapath.sv
module fcl_datapath
  import fcl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              serialMode,
  input  logic [LEN_W-1:0]  totalLen,
  input  logic [DATA_W-1:0] inData,
  output logic              allSent,
  output logic              cfgReqN,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgData,
  output logic [LEN_W-1:0]  byteCount
);

  logic [DATA_W-1:0] shReg;
  logic [LEN_W-1:0]  lenReg;

  // Serial mode presents only the lowest bit of the shift register
  assign cfgData = serialMode ? DATA_W'(shReg[0]) : shReg;
  assign allSent = (byteCount == lenReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReqN <= 1'b1;
      cfgClk  <= 1'b0;
    end else begin
      if (stb.cfgLow)       cfgReqN <= 1'b0;
      else if (stb.cfgHigh) cfgReqN <= 1'b1;
      if (stb.clkRise)      cfgClk  <= 1'b1;
      else if (stb.clkFall) cfgClk  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      lenReg    <= '0;
      byteCount <= '0;
    end else begin
      if (stb.startXfer) begin
        shReg     <= '0;
        lenReg    <= totalLen;
        byteCount <= '0;
      end else begin
        if (stb.loadByte)      shReg <= inData;
        else if (stb.shiftBit) shReg <= shReg >> 1;
        if (stb.countByte)     byteCount <= byteCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import fcl_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ  = 50_000_000,
  parameter int unsigned PULSE_US     = 5,
  parameter int unsigned SETTLE_US    = 100,
  parameter int unsigned HALF_CYC     = 2,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned LEN_W        = 16,
  parameter int unsigned SECURE_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  totalLen,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              tgtStatus,
  input  logic              tgtDone,
  output logic              cfgReqN,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgData,
  output logic              busy,
  output logic              xferOk,
  output logic              xferFail,
  output logic              abortReq,
  output logic [LEN_W-1:0]  byteCount
);

  localparam int unsigned PULSE_CYC  = usToCycles(CLK_FREQ_HZ, PULSE_US);
  localparam int unsigned SETTLE_CYC = usToCycles(CLK_FREQ_HZ, SETTLE_US);

  dpStrobe_t stb;
  logic      serialMode;
  logic      allSent;
  logic      lenZero;

  assign lenZero = (totalLen == '0);

  fcl_ctrl #(
    .DATA_W      (DATA_W),
    .SECURE_EXTRA(SECURE_EXTRA),
    .PULSE_CYC   (PULSE_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .HALF_CYC    (HALF_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .mode      (mode),
    .lenZero   (lenZero),
    .allSent   (allSent),
    .tgtStatus (tgtStatus),
    .tgtDone   (tgtDone),
    .inValid   (inValid),
    .inReady   (inReady),
    .busy      (busy),
    .xferOk    (xferOk),
    .xferFail  (xferFail),
    .abortReq  (abortReq),
    .serialMode(serialMode),
    .stb       (stb)
  );

  fcl_datapath #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .serialMode(serialMode),
    .totalLen  (totalLen),
    .inData    (inData),
    .allSent   (allSent),
    .cfgReqN   (cfgReqN),
    .cfgClk    (cfgClk),
    .cfgData   (cfgData),
    .byteCount (byteCount)
  );

endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [LEN_W-1:0]  totalLen,
  input logic              busy,
  input logic              cfgReqN,
  input logic              cfgClk,
  input logic [DATA_W-1:0] cfgData,
  input logic              inReady,
  input logic              tgtStatus,
  input logic              xferOk,
  input logic              xferFail,
  input logic              abortReq
);

  // R3: data moves only while the configuration clock is low
  a_r3_data_moves_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgData) |-> !cfgClk);

  // R3: data is held across each rising edge
  a_r3_rise_holds_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  // R1: request released whenever the block is idle
  a_r1_req_high_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> cfgReqN);

  // R2: no clock while the request is held low
  a_r2_no_clock_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReqN |-> !cfgClk);

  // R10: byte taken only while busy, target healthy and clock low
  a_r10_ready_gated: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && tgtStatus && !cfgClk));

  // R8: success and failure never together
  a_r8_result_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(xferOk && xferFail));

  // R7: abort appears together with a failure report
  a_r7_abort_with_fail: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortReq) |-> xferFail);

  // R9: empty request rejected at once
  a_r9_empty_reject: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (totalLen == '0)) |=> (xferFail && !busy && cfgReqN));

  // R11: an accepted start clears the abort request
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> !abortReq);

endmodule

bind fpga_cfg_loader fcl_checker #(
  .DATA_W(DATA_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .totalLen (totalLen),
  .busy     (busy),
  .cfgReqN  (cfgReqN),
  .cfgClk   (cfgClk),
  .cfgData  (cfgData),
  .inReady  (inReady),
  .tgtStatus(tgtStatus),
  .xferOk   (xferOk),
  .xferFail (xferFail),
  .abortReq (abortReq)
);

// File: tb/fpga_cfg_loader_bench.sv
`timescale 1ns/1ps
module fpga_cfg_loader_bench;

  localparam int CLK_HZ = 2_000_000;
  localparam int H      = 2;
  localparam int P      = 10;   // 5 us at 2 cycles per us
  localparam int S      = 200;  // 100 us at 2 cycles per us

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] totalLen = '0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        tgtStatus = 1'b1;
  logic        tgtDone = 1'b1;
  logic        cfgReqN, cfgClk, busy, xferOk, xferFail, abortReq;
  logic [7:0]  cfgData;
  logic [15:0] byteCount;

  int checks = 0;
  int errors = 0;
  int okSeen = 0;
  int failSeen = 0;
  bit modelOn = 1'b0;
  bit stallOn = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic [7:0] srcQ[$];

  // Reference expectations
  bit expCfgN = 1, expDclk = 0, expBusy = 0, expOk = 0, expFail = 0, expAbort = 0, expFetch = 0;
  int expDout = 0, expCount = 0, curMode = 1, curLen = 0;

  always #5 clk = ~clk;

  fpga_cfg_loader #(
    .CLK_FREQ_HZ(CLK_HZ), .PULSE_US(5), .SETTLE_US(100), .HALF_CYC(H),
    .DATA_W(8), .LEN_W(16), .SECURE_EXTRA(3)
  ) u_fpga_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .totalLen(totalLen),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .tgtStatus(tgtStatus), .tgtDone(tgtDone),
    .cfgReqN(cfgReqN), .cfgClk(cfgClk), .cfgData(cfgData), .busy(busy),
    .xferOk(xferOk), .xferFail(xferFail), .abortReq(abortReq), .byteCount(byteCount)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Byte source with optional stalls
  always @(posedge clk) begin
    if (rstN && inValid && inReady && srcQ.size() > 0) void'(srcQ.pop_front());
  end

  always @(negedge clk) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    inValid <= (srcQ.size() > 0) && !(stallOn && lfsr[0]);
    inData  <= (srcQ.size() > 0) ? srcQ[0] : 8'h00;
  end

  // Behavioural model of one transfer, stepping by edge counts
  task automatic modelXfer();
    int mLen, beatsPer;
    logic [7:0] b;
    curMode = int'(mode);
    mLen = int'(totalLen);
    curLen = mLen;
    expCfgN = 0; expBusy = 1; expCount = 0; expDout = 0;
    repeat (P) @(posedge clk);
    expCfgN = 1;
    repeat (S) @(posedge clk);
    expFetch = 1;
    forever begin
      @(posedge clk);
      if (expCount == mLen) begin
        expFetch = 0; expDclk = 1;
        repeat (S) @(posedge clk);
        expDclk = 0; expBusy = 0;
        if (tgtDone) expOk = 1;
        else begin expFail = 1; expAbort = 1; end
        return;
      end else if (!tgtStatus) begin
        expFetch = 0; expBusy = 0; expFail = 1; expAbort = 1;
        return;
      end else if (inValid) begin
        b = inData;
        expFetch = 0;
        beatsPer = (curMode == 0) ? 8 : ((curMode >= 2) ? 4 : 1);
        expDout = (curMode == 0) ? int'(b[0]) : int'(b);
        for (int k = 0; k < beatsPer; k++) begin
          repeat (H) @(posedge clk);
          expDclk = 1;
          repeat (H) @(posedge clk);
          expDclk = 0;
          if (curMode == 0 && k < beatsPer - 1) expDout = int'(b[k+1]);
        end
        expCount++;
        expFetch = 1;
      end
    end
  endtask

  initial begin
    @(posedge rstN);
    modelOn = 1'b1;
    forever begin
      @(posedge clk);
      expOk = 0; expFail = 0;
      if (start) begin
        expAbort = 0;
        if (totalLen == 0) expFail = 1;
        else modelXfer();
      end
    end
  end

  // Per-cycle comparison, just before each rising edge
  always @(negedge clk) begin
    if (rstN && modelOn) begin
      #3;
      cmp("R1 cfgReqN", int'(cfgReqN), int'(expCfgN));
      cmp("R3 cfgClk", int'(cfgClk), int'(expDclk));
      if (curMode == 0)      cmp("R4 cfgData", int'(cfgData), expDout);
      else if (curMode == 1) cmp("R5 cfgData", int'(cfgData), expDout);
      else                   cmp("R6 cfgData", int'(cfgData), expDout);
      cmp("R1 busy", int'(busy), int'(expBusy));
      cmp("R8 xferOk", int'(xferOk), int'(expOk));
      cmp("R7 xferFail", int'(xferFail), int'(expFail));
      cmp("R11 abortReq", int'(abortReq), int'(expAbort));
      cmp("R7 byteCount", int'(byteCount), expCount);
      cmp("R10 inReady", int'(inReady),
          int'(expFetch && tgtStatus && (expCount != curLen)));
      if (xferOk) okSeen++;
      if (xferFail) failSeen++;
    end
  end

  task automatic pulseStart(input logic [1:0] m, input int len);
    @(negedge clk);
    mode = m; totalLen = 16'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    int ok0, fail0;
    // R12 reset state
    repeat (3) @(negedge clk);
    cmp("R12 cfgReqN", int'(cfgReqN), 1);
    cmp("R12 cfgClk", int'(cfgClk), 0);
    cmp("R12 cfgData", int'(cfgData), 0);
    cmp("R12 busy", int'(busy), 0);
    cmp("R12 flags", int'({xferOk, xferFail, abortReq}), 0);
    cmp("R12 byteCount", int'(byteCount), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R5 parallel, three bytes; R11 start while busy ignored
    ok0 = okSeen;
    srcQ.push_back(8'h3c); srcQ.push_back(8'hc3); srcQ.push_back(8'h81);
    pulseStart(2'b01, 3);
    repeat (40) @(negedge clk);
    pulseStart(2'b00, 0);
    waitIdle();
    cmp("R8 success reported", okSeen - ok0, 1);
    cmp("R5 bytes sent", int'(byteCount), 3);

    // R4 serial, two bytes with stalls
    ok0 = okSeen; stallOn = 1'b1;
    srcQ.push_back(8'ha5); srcQ.push_back(8'h6e);
    pulseStart(2'b00, 2);
    waitIdle();
    cmp("R4 success reported", okSeen - ok0, 1);
    cmp("R3 stalled bytes sent", int'(byteCount), 2);

    // R6 secure, done stays low -> failure and abort
    fail0 = failSeen; stallOn = 1'b0; tgtDone = 1'b0;
    srcQ.push_back(8'h12); srcQ.push_back(8'hf0);
    pulseStart(2'b10, 2);
    waitIdle();
    cmp("R8 failure on done low", failSeen - fail0, 1);
    cmp("R8 abortReq held", int'(abortReq), 1);
    tgtDone = 1'b1;

    // R7 status drops after two bytes
    fail0 = failSeen; stallOn = 1'b1;
    srcQ.push_back(8'h01); srcQ.push_back(8'h02);
    srcQ.push_back(8'h03); srcQ.push_back(8'h04);
    pulseStart(2'b01, 4);
    cmp("R11 abort cleared by start", int'(abortReq), 0);
    while (byteCount != 16'd2 && busy) @(negedge clk);
    tgtStatus = 1'b0;
    waitIdle();
    cmp("R7 failure reported", failSeen - fail0, 1);
    cmp("R7 bytes before error", int'(byteCount), 2);
    cmp("R7 abortReq", int'(abortReq), 1);
    cmp("R7 leftover bytes untouched", srcQ.size(), 2);
    srcQ.delete();
    tgtStatus = 1'b1; stallOn = 1'b0;

    // R9 zero length rejected, no pin activity
    fail0 = failSeen;
    pulseStart(2'b01, 0);
    repeat (4) @(negedge clk);
    cmp("R9 failure reported", failSeen - fail0, 1);
    cmp("R9 busy stays low", int'(busy), 0);
    cmp("R9 cfgReqN unchanged", int'(cfgReqN), 1);

    // R6 secure success after a failure
    ok0 = okSeen;
    srcQ.push_back(8'h99);
    pulseStart(2'b11, 1);
    waitIdle();
    cmp("R6 success reported", okSeen - ok0, 1);
    cmp("R11 abortReq clear", int'(abortReq), 0);

    finishRun();
  end

endmodule